// File: doc/BRIEF.md
# Tick-Counted PWM Generator with Auto-Off Timer

A single-channel pulse-width modulator whose period, duty and auto-off interval are set through a byte-wide register write port. Time is measured in ticks of an 8 MHz time base (125 ns per tick). A parameter gives how many clock cycles form one tick, so the block can run directly from the time base or from a faster clock. Period and duty are 16-bit tick counts. The output is high from the start of each period for the duty count, then low for the rest of the period.

Each 16-bit value is written as two bytes. A write to the high byte only stages it. The full value takes effect in the same cycle as the write to its low byte, so a half-written value never drives the output. An enable bit gates the output. An optional auto-off interval, counted in milliseconds, clears the enable bit in hardware when it runs out. The all-ones interval turns the auto-off timer off.

The write port is a control interface, not a stream. Every strobe is accepted in the cycle it is presented. The port has no ready signal and never applies back-pressure. No register can be read back.

Top module: `pwm_autooff`

## Requirements
- R1: After reset the output is low, period and duty are 0, the enable bit is 0 and the auto-off interval is 0xFFFF. Setting only the enable bit therefore leaves the output low.
- R2: A write to a high-byte register (0xA5 period, 0xA7 duty, 0xA1 auto-off) changes nothing observable. The staged byte becomes the upper half of the value when the matching low byte (0xA4, 0xA6, 0xA2) is written, and the new value acts from the next cycle.
- R3: With 0 < duty < period, every period lasts `period` ticks, and the output is high for the first `duty` ticks of it and low for the rest.
- R4: A duty of 0 keeps the output low. A nonzero duty that is greater than or equal to the period keeps the output high.
- R5: Register 0xA3 bit 0 is the enable bit, and the other bits are ignored. While it is 0 the output is low and the tick counter is held at 0, so a period starts afresh when the output is enabled again.
- R6: When a new period is committed and the tick counter is at or beyond it, the counter restarts at 0 in the next cycle.
- R7: With an auto-off interval N other than 0xFFFF, the enable bit is cleared after N milliseconds of enabled time, where one millisecond is MS_TICKS ticks. An interval of 0 behaves as 1. Writing the low byte 0xA2 reloads the interval and restarts the millisecond count.
- R8: An auto-off interval of 0xFFFF never counts down and never clears the enable bit.
- R9: If a write to 0xA3 falls in the same cycle as an auto-off expiry, the written value wins.
- R10: A write to any address outside 0xA1 to 0xA7 has no effect.
- R11: One tick lasts TICK_DIV clock cycles, so a period of P ticks spans P × TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; TICK_DIV cycles form one 125 ns tick |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, accepted in the same cycle |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | PWM output, active high |

## Verification
Two functions can fall in the same cycle: a host write to the enable register and a hardware expiry of the auto-off timer. The bench keeps a cycle-level reference model. It uses that model to find the edge where the timer will expire and drives an enable write of 1 on exactly that edge. The result is judged by the output staying high after that edge and then dropping one millisecond later, when the now-zero interval expires again. A period commit landing on the counter's wrap edge, or on a counter already beyond the new period, is provoked by random period writes while the output runs, and is judged against the model every cycle.

// File: rtl/pwm_autooff_pkg.sv
package pwm_autooff_pkg;
  localparam int BYTE_W = 8;
  localparam int VAL_W  = 2 * BYTE_W;
  localparam int NPAIR  = 3;

  localparam logic [BYTE_W-1:0] ADDR_AO_HI   = 8'hA1;
  localparam logic [BYTE_W-1:0] ADDR_AO_LO   = 8'hA2;
  localparam logic [BYTE_W-1:0] ADDR_ENA     = 8'hA3;
  localparam logic [BYTE_W-1:0] ADDR_PER_LO  = 8'hA4;
  localparam logic [BYTE_W-1:0] ADDR_PER_HI  = 8'hA5;
  localparam logic [BYTE_W-1:0] ADDR_DUTY_LO = 8'hA6;
  localparam logic [BYTE_W-1:0] ADDR_DUTY_HI = 8'hA7;

  localparam int PAIR_AO   = 0;
  localparam int PAIR_PER  = 1;
  localparam int PAIR_DUTY = 2;

  typedef logic [VAL_W-1:0] tval_t;

  localparam tval_t AO_OFF = '1;

  typedef struct packed {
    logic  hit;
    tval_t val;
  } commit_t;

  function automatic logic [BYTE_W-1:0] pair_hi_addr(input int idx);
    case (idx)
      PAIR_AO:  return ADDR_AO_HI;
      PAIR_PER: return ADDR_PER_HI;
      default:  return ADDR_DUTY_HI;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] pair_lo_addr(input int idx);
    case (idx)
      PAIR_AO:  return ADDR_AO_LO;
      PAIR_PER: return ADDR_PER_LO;
      default:  return ADDR_DUTY_LO;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] pair_stage_rst(input int idx);
    return (idx == PAIR_AO) ? 8'hFF : 8'h00;
  endfunction
endpackage

// File: rtl/pwm_autooff_tickgen.sv
module pwm_autooff_tickgen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_autooff_pair.sv
module pwm_autooff_pair
  import pwm_autooff_pkg::*;
#(
  parameter logic [BYTE_W-1:0] HI_ADDR   = 8'h00,
  parameter logic [BYTE_W-1:0] LO_ADDR   = 8'h00,
  parameter logic [BYTE_W-1:0] STAGE_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output commit_t           commit
);
  logic [BYTE_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                           stage_q <= STAGE_RST;
    else if (wr_en && wr_addr == HI_ADDR) stage_q <= wr_data;
  end

  assign commit.hit = wr_en && (wr_addr == LO_ADDR);
  assign commit.val = {stage_q, wr_data};
endmodule

// File: rtl/pwm_autooff_regs.sv
module pwm_autooff_regs
  import pwm_autooff_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              expire,
  output commit_t           ao_cm,
  output commit_t           per_cm,
  output commit_t           duty_cm,
  output logic              enable
);
  commit_t cm [NPAIR];
  logic    ena_hit;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    pwm_autooff_pair #(
      .HI_ADDR  (pair_hi_addr(g)),
      .LO_ADDR  (pair_lo_addr(g)),
      .STAGE_RST(pair_stage_rst(g))
    ) u_pair (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .commit (cm[g])
    );
  end

  assign ao_cm   = cm[PAIR_AO];
  assign per_cm  = cm[PAIR_PER];
  assign duty_cm = cm[PAIR_DUTY];

  assign ena_hit = wr_en && (wr_addr == ADDR_ENA);

  // A host write has priority over the hardware clear.
  always_ff @(posedge clk) begin
    if (!rst_n)       enable <= 1'b0;
    else if (ena_hit) enable <= wr_data[0];
    else if (expire)  enable <= 1'b0;
  end
endmodule

// File: rtl/pwm_autooff_wave.sv
module pwm_autooff_wave
  import pwm_autooff_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    enable,
  input  commit_t per_cm,
  input  commit_t duty_cm,
  output tval_t   period,
  output tval_t   duty,
  output tval_t   cnt,
  output logic    pwm_out
);
  tval_t eff_per;

  // The period in force from this edge on: a commit acts at once.
  assign eff_per = per_cm.hit ? per_cm.val : period;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0;
      duty   <= '0;
    end else begin
      if (per_cm.hit)  period <= per_cm.val;
      if (duty_cm.hit) duty   <= duty_cm.val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!enable)          cnt <= '0;
    else if (cnt >= eff_per)   cnt <= '0;
    else if (tick) begin
      if (cnt == eff_per - 1'b1) cnt <= '0;
      else                       cnt <= cnt + 1'b1;
    end
  end

  assign pwm_out = enable && (duty != '0) && ((duty >= period) || (cnt < duty));
endmodule

// File: rtl/pwm_autooff_timer.sv
module pwm_autooff_timer
  import pwm_autooff_pkg::*;
#(
  parameter int MS_TICKS = 8000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    enable,
  input  commit_t ao_cm,
  output tval_t   ao_val,
  output logic    expire
);
  localparam int MS_W = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_TICKS - 1);

  logic [MS_W-1:0] pre_q;
  logic            armed;
  logic            ms_edge;
  logic            step;

  assign armed   = enable && (ao_val != AO_OFF);
  assign ms_edge = tick && (pre_q == MS_LAST);
  assign step    = armed && ms_edge && !ao_cm.hit;
  assign expire  = step && (ao_val <= tval_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ao_val <= AO_OFF;
      pre_q  <= '0;
    end else if (ao_cm.hit) begin
      ao_val <= ao_cm.val;
      pre_q  <= '0;
    end else if (!armed) begin
      pre_q  <= '0;
    end else if (tick) begin
      if (ms_edge) begin
        pre_q  <= '0;
        ao_val <= expire ? '0 : ao_val - 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_autooff.sv
module pwm_autooff
  import pwm_autooff_pkg::*;
#(
  parameter int TICK_DIV = 1,
  parameter int MS_TICKS = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       pwm_out
);
  logic    tick;
  logic    enable;
  logic    expire;
  commit_t ao_cm;
  commit_t per_cm;
  commit_t duty_cm;
  tval_t   period;
  tval_t   duty;
  tval_t   cnt;
  tval_t   ao_val;

  pwm_autooff_tickgen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  pwm_autooff_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .expire (expire),
    .ao_cm  (ao_cm),
    .per_cm (per_cm),
    .duty_cm(duty_cm),
    .enable (enable)
  );

  pwm_autooff_wave u_wave (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .enable (enable),
    .per_cm (per_cm),
    .duty_cm(duty_cm),
    .period (period),
    .duty   (duty),
    .cnt    (cnt),
    .pwm_out(pwm_out)
  );

  pwm_autooff_timer #(.MS_TICKS(MS_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .enable(enable),
    .ao_cm (ao_cm),
    .ao_val(ao_val),
    .expire(expire)
  );
endmodule

// File: rtl/pwm_autooff_chk.sv
module pwm_autooff_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic        wr_bit0,
  input logic        enable,
  input logic        expire,
  input logic [15:0] period,
  input logic [15:0] duty,
  input logic [15:0] cnt,
  input logic [15:0] ao_val,
  input logic        pwm_out
);
  logic unmapped;
  assign unmapped = wr_en && ((wr_addr < 8'hA1) || (wr_addr > 8'hA7));

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pwm_out); // R5

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'd0) || (cnt < period)); // R6

  AST_PER_HI_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'hA5) |=> $stable(period)); // R2

  AST_DUTY_HI_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'hA7) |=> $stable(duty)); // R2

  AST_EXPIRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !(wr_en && wr_addr == 8'hA3)) |=> !enable); // R7

  AST_WRITE_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && wr_en && wr_addr == 8'hA3 && wr_bit0) |=> enable); // R9

  AST_SENTINEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ao_val == 16'hFFFF && !(wr_en && wr_addr == 8'hA2)) |=> (ao_val == 16'hFFFF)); // R8

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> ($stable(period) && $stable(duty))); // R10
endmodule

bind pwm_autooff pwm_autooff_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_bit0(wr_data[0]),
  .enable (enable),
  .expire (expire),
  .period (period),
  .duty   (duty),
  .cnt    (cnt),
  .ao_val (ao_val),
  .pwm_out(pwm_out)
);

// File: tb/pwm_autooff_tb_top.sv
`timescale 1ns/1ps
module pwm_autooff_tb_top;
  localparam int TD = 2;
  localparam int MS = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       pwm_out;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pwm_autooff #(.TICK_DIV(TD), .MS_TICKS(MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // Reference model, written from the requirements
  int          m_div;
  bit          m_en;
  logic [15:0] m_per, m_duty, m_cnt, m_ao;
  int          m_pre;
  logic [7:0]  m_ps, m_ds, m_as;

  always @(posedge clk) begin : mdl
    bit          tk, armed, step, expire;
    logic [7:0]  wa;
    logic [15:0] ep;
    if (!rst_n) begin
      m_div <= 0; m_en <= 0; m_per <= 0; m_duty <= 0; m_cnt <= 0;
      m_ao <= 16'hFFFF; m_pre <= 0; m_ps <= 0; m_ds <= 0; m_as <= 8'hFF;
    end else begin
      tk = (m_div == TD - 1);
      wa = wr_en ? wr_addr : 8'h00;
      ep = (wa == 8'hA4) ? {m_ps, wr_data} : m_per;
      armed = m_en && (m_ao != 16'hFFFF);
      step = armed && tk && (m_pre == MS - 1) && (wa != 8'hA2);
      expire = step && (m_ao <= 16'd1);
      m_div <= tk ? 0 : m_div + 1;
      if (!m_en) m_cnt <= 0;
      else if (m_cnt >= ep) m_cnt <= 0;
      else if (tk) m_cnt <= (m_cnt == ep - 16'd1) ? 16'd0 : m_cnt + 16'd1;
      if (wa == 8'hA4) m_per <= ep;
      if (wa == 8'hA6) m_duty <= {m_ds, wr_data};
      if (wa == 8'hA5) m_ps <= wr_data;
      if (wa == 8'hA7) m_ds <= wr_data;
      if (wa == 8'hA1) m_as <= wr_data;
      if (wa == 8'hA2) begin m_ao <= {m_as, wr_data}; m_pre <= 0; end
      else if (!armed) m_pre <= 0;
      else if (tk) begin
        if (m_pre == MS - 1) begin m_pre <= 0; m_ao <= expire ? 16'd0 : m_ao - 16'd1; end
        else m_pre <= m_pre + 1;
      end
      if (wa == 8'hA3) m_en <= wr_data[0];
      else if (expire) m_en <= 0;
    end
  end

  function automatic logic exp_out();
    return m_en && (m_duty != 0) && ((m_duty >= m_per) || (m_cnt < m_duty));
  endfunction

  function automatic bit expiry_next();
    return m_en && (m_ao != 16'hFFFF) && (m_div == TD - 1) && (m_pre == MS - 1) && (m_ao <= 16'd1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on && !done) chk(cur_req, int'(pwm_out), int'(exp_out()));

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
  endtask

  task automatic wr16(input logic [7:0] hi_a, input logic [7:0] lo_a, input logic [15:0] v);
    wr(hi_a, v[15:8]);
    wr(lo_a, v[7:0]);
  endtask

  task automatic highs(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  initial begin
    int h;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1", int'(pwm_out), 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    @(negedge clk);

    // R1: enable alone, duty still 0 from reset
    cur_req = "R1";
    wr(8'hA3, 8'h01);
    highs(20, h); chk("R1", h, 0);

    // R3: period 10, duty 4
    cur_req = "R3";
    wr16(8'hA5, 8'hA4, 16'd10);
    wr16(8'hA7, 8'hA6, 16'd4);
    highs(10 * TD, h); chk("R3", h, 4 * TD);

    // R2: high byte alone changes nothing; low byte commits
    cur_req = "R2";
    wr(8'hA7, 8'h01);
    highs(10 * TD, h); chk("R2", h, 4 * TD);
    wr(8'hA6, 8'h00);
    highs(10 * TD, h); chk("R2", h, 10 * TD);

    // R11: period 6 duty 2 spans 12 cycles
    cur_req = "R11";
    wr16(8'hA5, 8'hA4, 16'd6);
    wr16(8'hA7, 8'hA6, 16'd2);
    highs(6 * TD, h); chk("R11", h, 2 * TD);

    // R4: duty 0 low, duty == period high
    cur_req = "R4";
    wr16(8'hA7, 8'hA6, 16'd0);
    highs(6 * TD, h); chk("R4", h, 0);
    wr16(8'hA7, 8'hA6, 16'd6);
    highs(6 * TD, h); chk("R4", h, 6 * TD);

    // R6: shrink period below the running counter
    cur_req = "R6";
    wr16(8'hA7, 8'hA6, 16'd5);
    wr16(8'hA5, 8'hA4, 16'd200);
    repeat (150) @(negedge clk);
    chk("R6", int'(pwm_out), 0);
    wr(8'hA4, 8'd20);
    chk("R6", int'(pwm_out), 1);

    // R5: disable forces low; re-enable restarts the period
    cur_req = "R5";
    repeat (17) @(negedge clk);
    wr(8'hA3, 8'hFE);
    highs(40, h); chk("R5", h, 0);
    wr(8'hA3, 8'h03);
    chk("R5", int'(pwm_out), 1);

    // R7: auto-off of 2 ms with full-high output
    cur_req = "R7";
    wr16(8'hA5, 8'hA4, 16'd4);
    wr16(8'hA7, 8'hA6, 16'd4);
    wr(8'hA3, 8'h00);
    wr16(8'hA1, 8'hA2, 16'd2);
    wr(8'hA3, 8'h01);
    h = 0;
    while (pwm_out && h < 1000) begin h++; @(negedge clk); end
    chk("R7", int'(h >= 2 * MS * TD - TD && h <= 2 * MS * TD + TD), 1);

    // R8: all-ones interval never expires
    cur_req = "R8";
    wr16(8'hA1, 8'hA2, 16'hFFFF);
    wr(8'hA3, 8'h01);
    highs(10 * MS * TD, h); chk("R8", h, 10 * MS * TD);

    // R9: enable write on the expiry edge wins
    cur_req = "R9";
    wr16(8'hA1, 8'hA2, 16'd1);
    h = 0;
    while (!expiry_next() && h < 2000) begin h++; @(negedge clk); end
    chk("R9", int'(expiry_next()), 1);
    wr(8'hA3, 8'h01);
    chk("R9", int'(pwm_out), 1);
    h = 0;
    while (pwm_out && h < 1000) begin h++; @(negedge clk); end
    chk("R9", int'(h >= MS * TD - TD && h <= MS * TD + TD), 1);

    // R10: unmapped writes have no effect
    cur_req = "R10";
    wr16(8'hA1, 8'hA2, 16'hFFFF);
    wr16(8'hA5, 8'hA4, 16'd10);
    wr16(8'hA7, 8'hA6, 16'd4);
    wr(8'hA3, 8'h01);
    wr(8'hA0, 8'h00); wr(8'hA8, 8'h00); wr(8'h00, 8'h55); wr(8'hFF, 8'hFF);
    highs(10 * TD, h); chk("R10", h, 4 * TD);

    // Random traffic checked against the model every cycle
    cur_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) begin
        case ($urandom_range(7))
          0: wr(8'hA3, 8'($urandom_range(255)));
          1: wr(8'hA1, $urandom_range(1) ? 8'hFF : 8'h00);
          2: wr(8'hA2, $urandom_range(1) ? 8'hFF : 8'($urandom_range(3)));
          3: wr(8'hA4, 8'($urandom_range(15)));
          4: wr(8'hA5, ($urandom_range(7) == 0) ? 8'h01 : 8'h00);
          5: wr(8'hA6, 8'($urandom_range(15)));
          6: wr(8'hA7, ($urandom_range(7) == 0) ? 8'h01 : 8'h00);
          default: wr(8'($urandom_range(160)), 8'($urandom_range(255)));
        endcase
      end else begin
        @(negedge clk);
      end
    end
    finish_run();
  end
endmodule